// File: doc/BRIEF.md
# Row-Column Block Parity Encoder

This block produces a 24-bit check word for a 256-byte data block, so that a later reader can locate and flip a single corrupted bit or flag a double-bit fault. Bytes stream in one per clock over a valid/ready handshake. The first byte of a block carries a start marker and the final byte carries an end marker. While the block streams, the encoder keeps three running results. The first is a row parity for each byte, sorted into complementary pairs by the bits of the byte index. The second is a running XOR of all data bytes, the column byte. The third is a parity over all data bits. Nothing is stored apart from these accumulators.

One cycle after the 256th byte is accepted, the encoder raises an output strobe for a single cycle and presents the check word. The word holds its value until the next block completes. The input side stalls only during that strobe cycle, so a new block can begin on the following cycle. A block with bad framing sets a sticky error flag. While that flag is set, the strobe is held low until reset.

Top module: `rowcol_parity_enc`

## Requirements
- R1: After reset, `out_valid` is 0, `frame_err` is 0, `in_ready` is 1 and `out_check` is 0.
- R2: `out_check[15:0]` carries row parities. Bit 2k is the XOR of the 1-bit parities of every byte whose index (0..255, in arrival order) has bit k equal to 0. Bit 2k+1 is the same over the bytes whose index bit k is 1, for k = 0..7.
- R3: Let C be the XOR of all 256 bytes. `out_check[21:16]` holds six parities of C. Bit 16+2k is the XOR of the bits of C at positions whose bit k is 0, and bit 17+2k covers positions whose bit k is 1, for k = 0..2. This is the same as the masks 0x55, 0xAA, 0x33, 0xCC, 0x0F, 0xF0 in that order.
- R4: `out_check[22]` is the XOR of all 2048 data bits. Each complementary pair (bits 2k, 2k+1 of the row or column field) therefore XORs to bit 22.
- R5: `out_check[23]` is the XOR of `out_check[21:0]`.
- R6: `out_valid` is high for exactly one cycle, the cycle after the 256th byte of a block is accepted. `out_check` changes only at the start of that cycle and holds its value at all other times.
- R7: `in_ready` is low only during the `out_valid` cycle. A byte offered then is not taken. A new block may start in the next cycle, and idle cycles inside a block do not advance the byte index.
- R8: A byte accepted with `in_sob` low while no block is open is ignored. It does not affect the next check word or the error flag.
- R9: If `in_eob` is set on a byte whose index is not 255, or is clear on byte 255, `frame_err` goes high. It stays high and `out_valid` stays low until reset.
- R10: A start marker accepted while a block is open sets `frame_err` in the same way.
- R11: A start marker clears all accumulators, so earlier blocks do not affect the new check word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Encoder can take a byte |
| in_data | input | 8 | Data byte |
| in_sob | input | 1 | Offered byte is the first of a block |
| in_eob | input | 1 | Offered byte is the last of a block |
| out_valid | output | 1 | One-cycle strobe: `out_check` is new |
| out_check | output | 24 | Check word of the last completed block |
| frame_err | output | 1 | Sticky framing error flag |

## Verification
Any fault in the byte index, a row accumulator or the column byte stays hidden until the block ends. It then shows on `out_check` in the strobe cycle, at most 256 accepted bytes later. Single-bit data blocks at the first and last index tie each check bit to one address or bit-position bit, so a wrong pairing shows in the first word. A bad index counter also shows as a misplaced strobe or a spurious `frame_err` on the block's final byte. Missing stall or restart logic corrupts the word of the block that follows, which is why the back-to-back runs compare every word.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_BLOCK = 1'b1
   } rcp_state_e;

   // Width of the packed check word for a given byte width and index width.
   function automatic int rcp_check_width(input int data_w, input int addr_w);
      return 2 * addr_w + 2 * $clog2(data_w) + 2;
   endfunction

endpackage

// File: rtl/rcp_frame_ctl.sv
module rcp_frame_ctl
   import rcp_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sob,
   input  logic              in_eob,
   output logic              in_ready,
   output logic              take,
   output logic              restart,
   output logic              finish,
   output logic [ADDR_W-1:0] byte_idx,
   output logic              out_valid,
   output logic              frame_err
);

   rcp_state_e        state_q, state_d;
   logic [ADDR_W-1:0] cnt_q, cnt_d;
   logic              ov_q, err_q;
   logic              accept, in_blk, last_idx, err_now;

   always_comb begin
      in_ready = ~ov_q;
      accept   = in_valid & in_ready;
      in_blk   = (state_q == ST_BLOCK);
      take     = accept & (in_sob | in_blk);
      restart  = take & in_sob;
      byte_idx = in_sob ? '0 : cnt_q;
      last_idx = &byte_idx;
      err_now  = (accept & in_sob & in_blk) | (take & (in_eob != last_idx));
      finish   = take & last_idx & in_eob & ~err_now & ~err_q;
      state_d  = state_q;
      cnt_d    = cnt_q;
      if (take) begin
         if (err_now || last_idx) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
         end else begin
            state_d = ST_BLOCK;
            cnt_d   = ADDR_W'(byte_idx + 1'b1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ov_q    <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         ov_q    <= finish;
         err_q   <= err_q | err_now;
      end
   end

   assign out_valid = ov_q;
   assign frame_err = err_q;

endmodule

// File: rtl/rcp_row_acc.sv
module rcp_row_acc #(
   parameter int ADDR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic                restart,
   input  logic [ADDR_W-1:0]   byte_idx,
   input  logic                row_bit,
   output logic [2*ADDR_W-1:0] row_next
);

   localparam int NROW = 2 * ADDR_W;

   logic [NROW-1:0] acc_q, contrib, base;

   // Each index bit steers the byte's parity into one of a complementary pair.
   for (genvar k = 0; k < ADDR_W; k++) begin : g_pair
      assign contrib[2*k]   = row_bit & ~byte_idx[k];
      assign contrib[2*k+1] = row_bit &  byte_idx[k];
   end

   assign base     = restart ? '0 : acc_q;
   assign row_next = take ? (base ^ contrib) : acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= row_next;
   end

endmodule

// File: rtl/rcp_col_acc.sv
module rcp_col_acc #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              restart,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] col_next
);

   logic [DATA_W-1:0] acc_q, base;

   assign base     = restart ? '0 : acc_q;
   assign col_next = take ? (base ^ data) : acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= col_next;
   end

endmodule

// File: rtl/rcp_check_pack.sv
module rcp_check_pack #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic [2*ADDR_W-1:0]                          row,
   input  logic [DATA_W-1:0]                            col,
   output logic [2*ADDR_W+2*$clog2(DATA_W)+2-1:0]       check
);

   localparam int LOG_DW = $clog2(DATA_W);

   logic [2*LOG_DW-1:0] ycol;
   logic                all_par, par_par;

   for (genvar k = 0; k < LOG_DW; k++) begin : g_col
      logic [DATA_W-1:0] lo_m, hi_m;
      for (genvar p = 0; p < DATA_W; p++) begin : g_pos
         if (((p >> k) & 1) == 0) begin : g_lo
            assign lo_m[p] = col[p];
            assign hi_m[p] = 1'b0;
         end else begin : g_hi
            assign lo_m[p] = 1'b0;
            assign hi_m[p] = col[p];
         end
      end
      assign ycol[2*k]   = ^lo_m;
      assign ycol[2*k+1] = ^hi_m;
   end

   assign all_par = ^col;
   assign par_par = ^{ycol, row};
   assign check   = {par_par, all_par, ycol, row};

endmodule

// File: rtl/rowcol_parity_enc.sv
module rowcol_parity_enc #(
   parameter  int DATA_W  = 8,
   parameter  int ADDR_W  = 8,
   localparam int CHECK_W = 2 * ADDR_W + 2 * $clog2(DATA_W) + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [DATA_W-1:0]  in_data,
   input  logic               in_sob,
   input  logic               in_eob,
   output logic               out_valid,
   output logic [CHECK_W-1:0] out_check,
   output logic               frame_err
);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("rowcol_parity_enc: DATA_W must be a power of two of at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("rowcol_parity_enc: ADDR_W must lie in 1..16");
   end
   if (CHECK_W != rcp_pkg::rcp_check_width(DATA_W, ADDR_W)) begin : g_bad_check_w
      $error("rowcol_parity_enc: check width mismatch");
   end

   logic                take, restart, finish;
   logic [ADDR_W-1:0]   byte_idx;
   logic [2*ADDR_W-1:0] row_next;
   logic [DATA_W-1:0]   col_next;
   logic [CHECK_W-1:0]  check_d, check_q;

   rcp_frame_ctl #(.ADDR_W(ADDR_W)) i_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sob    (in_sob),
      .in_eob    (in_eob),
      .in_ready  (in_ready),
      .take      (take),
      .restart   (restart),
      .finish    (finish),
      .byte_idx  (byte_idx),
      .out_valid (out_valid),
      .frame_err (frame_err)
   );

   rcp_row_acc #(.ADDR_W(ADDR_W)) i_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .restart  (restart),
      .byte_idx (byte_idx),
      .row_bit  (^in_data),
      .row_next (row_next)
   );

   rcp_col_acc #(.DATA_W(DATA_W)) i_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .restart  (restart),
      .data     (in_data),
      .col_next (col_next)
   );

   rcp_check_pack #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_pack (
      .row   (row_next),
      .col   (col_next),
      .check (check_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      check_q <= '0;
      else if (finish) check_q <= check_d;
   end

   assign out_check = check_q;

endmodule

// File: rtl/rcp_checker.sv
module rcp_checker #(
   parameter  int DATA_W  = 8,
   parameter  int ADDR_W  = 8,
   localparam int CHECK_W = 2 * ADDR_W + 2 * $clog2(DATA_W) + 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic               in_eob,
   input logic               out_valid,
   input logic [CHECK_W-1:0] out_check,
   input logic               frame_err
);

   localparam int NPAIR = ADDR_W + $clog2(DATA_W);
   localparam int DP6   = CHECK_W - 2;

   assert_valid_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_valid_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready && in_eob));

   assert_check_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_check));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

   assert_no_valid_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !out_valid);

   assert_err_on_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> $past(in_valid && in_ready));

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair_chk
      assert_pair_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> ((out_check[2*k] ^ out_check[2*k+1]) == out_check[DP6]));
   end

endmodule

bind rowcol_parity_enc rcp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rcp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_eob    (in_eob),
   .out_valid (out_valid),
   .out_check (out_check),
   .frame_err (frame_err)
);

// File: tb/test_rowcol_parity_enc.sv
module test_rowcol_parity_enc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = 8'h00;
   logic        in_sob = 1'b0;
   logic        in_eob = 1'b0;
   logic        out_valid;
   logic [23:0] out_check;
   logic        frame_err;

   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [7:0]  blk [256];

   always #5 clk = ~clk;

   rowcol_parity_enc i_rowcol_parity_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_sob    (in_sob),
      .in_eob    (in_eob),
      .out_valid (out_valid),
      .out_check (out_check),
      .frame_err (frame_err)
   );

   function automatic logic [23:0] model();
      logic [15:0] x = '0;
      logic [5:0]  y = '0;
      logic [7:0]  c = '0;
      for (int i = 0; i < 256; i++) begin
         logic r = ^blk[i];
         c ^= blk[i];
         for (int k = 0; k < 8; k++) begin
            if (((i >> k) & 1) != 0) x[2*k+1] ^= r;
            else                     x[2*k]   ^= r;
         end
      end
      for (int k = 0; k < 3; k++) begin
         for (int p = 0; p < 8; p++) begin
            if (((p >> k) & 1) != 0) y[2*k+1] ^= c[p];
            else                     y[2*k]   ^= c[p];
         end
      end
      return {^{y, x}, ^c, y, x};
   endfunction

   task automatic check_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_sob   = 1'b0;
      in_eob   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Called at a negedge; returns at the negedge after the byte is taken.
   task automatic send_byte(input logic [7:0] d, input bit sob, input bit eob, input bit gap);
      if (gap) repeat ($urandom_range(0, 2)) @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      in_sob   = sob;
      in_eob   = eob;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_sob   = 1'b0;
      in_eob   = 1'b0;
   endtask

   task automatic run_block(input string req, input bit gaps, input bit post);
      logic [23:0] exp;
      for (int i = 0; i < 256; i++) send_byte(blk[i], i == 0, i == 255, gaps);
      exp = model();
      check_eq("R6", "strobe after last byte", 32'(out_valid), 32'd1);
      check_eq(req, "check word", 32'(out_check), 32'(exp));
      check_eq("R7", "ready low in strobe cycle", 32'(in_ready), 32'd0);
      if (post) begin
         @(negedge clk);
         check_eq("R6", "strobe width", 32'(out_valid), 32'd0);
         check_eq("R6", "word held", 32'(out_check), 32'(exp));
         check_eq("R7", "ready back", 32'(in_ready), 32'd1);
      end
   endtask

   task automatic fill_random();
      for (int i = 0; i < 256; i++) blk[i] = 8'($urandom);
   endtask

   task automatic fill_const(input logic [7:0] v);
      for (int i = 0; i < 256; i++) blk[i] = v;
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 150000 && !done) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=finish", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0005_EED1));
      do_reset();

      // R1: reset state
      check_eq("R1", "out_valid", 32'(out_valid), 32'd0);
      check_eq("R1", "frame_err", 32'(frame_err), 32'd0);
      check_eq("R1", "in_ready", 32'(in_ready), 32'd1);
      check_eq("R1", "out_check", 32'(out_check), 32'd0);

      // R2 / R3: single set bits at the index and position extremes
      fill_const(8'h00); blk[0] = 8'h01;
      run_block("R2", 1'b0, 1'b1);
      fill_const(8'h00); blk[255] = 8'h80;
      run_block("R3", 1'b0, 1'b1);
      fill_const(8'h00); blk[170] = 8'h10;
      run_block("R2", 1'b0, 1'b1);
      fill_const(8'h00); blk[85] = 8'h06; blk[3] = 8'h20;
      run_block("R3", 1'b1, 1'b1);

      // R4 / R5: uniform blocks
      fill_const(8'h00);
      run_block("R4", 1'b0, 1'b1);
      fill_const(8'hFF);
      run_block("R5", 1'b0, 1'b1);

      // Random blocks with idle gaps (R7 index holds across gaps)
      for (int b = 0; b < 3; b++) begin
         fill_random();
         run_block("R5", 1'b1, 1'b1);
      end

      // R7 / R11: back-to-back, first byte offered during the strobe cycle
      fill_random();
      run_block("R11", 1'b0, 1'b0);
      fill_random();
      run_block("R7", 1'b0, 1'b0);
      fill_random();
      run_block("R11", 1'b1, 1'b1);

      // R8: stray bytes with no block open
      for (int i = 0; i < 4; i++) send_byte(8'($urandom), 1'b0, i[0], 1'b0);
      check_eq("R8", "no strobe from stray", 32'(out_valid), 32'd0);
      check_eq("R8", "no error from stray", 32'(frame_err), 32'd0);
      check_eq("R8", "word unchanged", 32'(out_check), 32'(model()));
      fill_random();
      run_block("R8", 1'b0, 1'b1);

      // R9: end marker too early, then sticky through a good block
      for (int i = 0; i <= 100; i++) send_byte(8'($urandom), i == 0, i == 100, 1'b0);
      check_eq("R9", "early eob flag", 32'(frame_err), 32'd1);
      check_eq("R9", "early eob no strobe", 32'(out_valid), 32'd0);
      fill_random();
      for (int i = 0; i < 256; i++) send_byte(blk[i], i == 0, i == 255, 1'b0);
      check_eq("R9", "no strobe while flagged", 32'(out_valid), 32'd0);
      check_eq("R9", "flag sticky", 32'(frame_err), 32'd1);
      do_reset();
      check_eq("R1", "flag cleared by reset", 32'(frame_err), 32'd0);

      // R10: start marker inside an open block
      for (int i = 0; i < 10; i++) send_byte(8'($urandom), i == 0, 1'b0, 1'b0);
      check_eq("R10", "no flag yet", 32'(frame_err), 32'd0);
      send_byte(8'h3C, 1'b1, 1'b0, 1'b0);
      check_eq("R10", "flag on restart", 32'(frame_err), 32'd1);
      do_reset();

      // R9: 256th byte without end marker
      for (int i = 0; i < 256; i++) send_byte(8'($urandom), i == 0, 1'b0, 1'b0);
      check_eq("R9", "missing eob flag", 32'(frame_err), 32'd1);
      check_eq("R9", "missing eob no strobe", 32'(out_valid), 32'd0);
      do_reset();

      // Clean block after reset
      fill_random();
      run_block("R2", 1'b1, 1'b1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule